// File: doc/BRIEF.md
# Edge/Level Interrupt Collector

This block gathers up to 32 synchronous peripheral request lines into a status register that the processor can read. A mask register selects which status bits may reach the processor, and a single registered interrupt output goes high whenever any unmasked status bit is set. Vectoring, priority and nesting are left to software or to other logic.

One mode input picks the sensitivity for every line at once. In edge mode, a rising edge on a line sets its status bit. The bit then stays set until software writes a 0 to that position. In level mode, each status bit copies its line with one clock of delay. Software writes to the status register are ignored in level mode, so a bit clears only when the peripheral drops its request.

Registers are reached through a small port with a write strobe, a one-bit register select, write data and combinational read data.

Top module: `irq_collector`

## Requirements
- R1: While rst_ni is low and after it is released, the status register, the mask register and irq_o are all zero, and the controller works in edge mode.
- R2: In edge mode, a status bit is set at the clock edge where its line is 1 and was 0 at the previous edge. A line held high sets nothing more after its bit has been cleared.
- R3: In edge mode, a set status bit stays set after its request line falls.
- R4: In edge mode, writing the status register (reg_sel_i = 1) clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R5: In edge mode, a rising edge in the same cycle as a write of 0 to that bit leaves the bit set.
- R6: In level mode, each status bit equals its request line as sampled at the previous clock edge, so it clears one clock after the line falls.
- R7: In level mode, writes to the status register change no bit.
- R8: The mask register (reg_sel_i = 0) reads back exactly what was written. Status reads show every bit whatever the mask.
- R9: irq_o is a register that goes high one clock after (status AND mask) becomes non-zero, and low one clock after it becomes zero.
- R10: level_mode_i (1 = level, 0 = edge) takes effect at the second clock edge after it changes. The first edge still uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| level_mode_i | input | 1 | 1 selects level sensitivity, 0 selects edge |
| irq_req_i | input | N_IRQ | Peripheral request lines, synchronous to clk_i |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the mask register, 1 the status register |
| reg_wdata_i | input | N_IRQ | Write data |
| reg_rdata_o | output | N_IRQ | Read data for the selected register |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The main function is tried with four line patterns: a single-cycle pulse, a line held high across a software clear, a rising edge that coincides with a clearing write, and a level that rises and then falls. The pulse shows edge latching apart from level following. The held line shows that a level does not set the bit again once it has been cleared. The coincident case shows which of set and clear takes priority. The rise-and-fall pattern, run in both modes, shows the two ways a bit is cleared. Mask patterns with and without an overlapping status bit, together with the mode switch, show the one-clock latency of irq_o and of the mode change.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
  typedef enum logic {
    SEL_MASK   = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] req_i,
  output logic [N_IRQ-1:0] rise_o
);
  logic [N_IRQ-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= req_i;
  end

  assign rise_o = req_i & ~prev_q;

  // a rise needs a 0 on the previous edge
  AST_RISE_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rise_o & $past(req_i)) == '0)); // R2
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_collector_pkg::*;
#(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  trig_mode_e       mode_i,
  input  logic [N_IRQ-1:0] req_i,
  input  logic [N_IRQ-1:0] rise_i,
  input  logic             clr_wr_i,
  input  logic [N_IRQ-1:0] clr_data_i,
  output logic [N_IRQ-1:0] status_o
);
  logic [N_IRQ-1:0] status_q;

  for (genvar b = 0; b < N_IRQ; b++) begin : g_bit
    logic nxt;
    always_comb begin
      if (mode_i == MODE_LEVEL) begin
        nxt = req_i[b];
      end else begin
        // set beats a clearing write in the same cycle
        nxt = rise_i[b] | (status_q[b] & ~(clr_wr_i & ~clr_data_i[b]));
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[b] <= 1'b0;
      else         status_q[b] <= nxt;
    end
  end

  assign status_o = status_q;

  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE && !clr_wr_i) |=> ((status_q & $past(status_q)) == $past(status_q))); // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE) |=> ((status_q & $past(rise_i)) == $past(rise_i))); // R5
  AST_NO_SPONT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE) |=> ((status_q & ~$past(status_q) & ~$past(rise_i)) == '0)); // R2
  AST_LEVEL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LEVEL) |=> (status_q == $past(req_i))); // R6
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_IRQ-1:0] wdata_i,
  output logic [N_IRQ-1:0] mask_o
);
  logic [N_IRQ-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mask_q == $past(wdata_i))); // R8
  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q)); // R8
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] status_i,
  input  logic [N_IRQ-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & mask_i);
  end

  assign irq_o = irq_q;

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !irq_o); // R9
  AST_IRQ_NO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == '0) |=> !irq_o); // R9
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_collector_pkg::*;
#(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_mode_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [N_IRQ-1:0] reg_wdata_i,
  output logic [N_IRQ-1:0] reg_rdata_o,
  output logic             irq_o
);
  trig_mode_e       mode_q;
  logic [N_IRQ-1:0] rise;
  logic [N_IRQ-1:0] status;
  logic [N_IRQ-1:0] mask;
  logic             wr_mask;
  logic             wr_status;

  // mode register: edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_EDGE;
    else         mode_q <= level_mode_i ? MODE_LEVEL : MODE_EDGE;
  end

  assign wr_mask   = reg_we_i & (reg_sel_e'(reg_sel_i) == SEL_MASK);
  assign wr_status = reg_we_i & (reg_sel_e'(reg_sel_i) == SEL_STATUS);

  irq_edge_detect #(.N_IRQ(N_IRQ)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (irq_req_i),
    .rise_o(rise)
  );

  irq_status_bank #(.N_IRQ(N_IRQ)) i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_q),
    .req_i     (irq_req_i),
    .rise_i    (rise),
    .clr_wr_i  (wr_status),
    .clr_data_i(reg_wdata_i),
    .status_o  (status)
  );

  irq_mask_reg #(.N_IRQ(N_IRQ)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_mask),
    .wdata_i(reg_wdata_i),
    .mask_o (mask)
  );

  irq_out_stage #(.N_IRQ(N_IRQ)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status),
    .mask_i  (mask),
    .irq_o   (irq_o)
  );

  assign reg_rdata_o = (reg_sel_e'(reg_sel_i) == SEL_STATUS) ? status : mask;

  AST_MODE_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mode_q == ($past(level_mode_i) ? MODE_LEVEL : MODE_EDGE))); // R10
  AST_LEVEL_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LEVEL && wr_status) |=> (status == $past(irq_req_i))); // R7
endmodule

// File: tb/test_irq_collector.sv
`timescale 1ns/1ps
module test_irq_collector;
  localparam int unsigned N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         level_mode = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic         reg_we = 1'b0;
  logic         reg_sel = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_collector #(.N_IRQ(N)) i_irq_collector (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .level_mode_i(level_mode),
    .irq_req_i   (irq_req),
    .reg_we_i    (reg_we),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [N-1:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic sel, input logic [N-1:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    rd(1'b1, d); chk("R1 status after reset", d, '0);
    rd(1'b0, d); chk("R1 mask after reset", d, '0);
    chk("R1 irq_o after reset", {{(N-1){1'b0}}, irq}, '0);
  endtask

  task automatic t_mask_rw;
    logic [N-1:0] d;
    wr(1'b0, 32'hA5A5_0F0F);
    rd(1'b0, d); chk("R8 mask readback", d, 32'hA5A5_0F0F);
    wr(1'b0, '0);
    rd(1'b0, d); chk("R8 mask readback zero", d, '0);
  endtask

  task automatic t_edge_pulse;
    logic [N-1:0] d;
    irq_req[3] = 1'b1;
    tick(1);
    irq_req[3] = 1'b0;
    rd(1'b1, d); chk("R2 edge sets bit 3", d, 32'h8);
    tick(3);
    rd(1'b1, d); chk("R3 bit 3 held after line fell, unmasked read R8", d, 32'h8);
    chk("R9 irq_o low with mask zero", {{(N-1){1'b0}}, irq}, '0);
  endtask

  task automatic t_irq_out;
    logic [N-1:0] d;
    wr(1'b0, 32'h8);
    chk("R9 irq_o not yet high", {{(N-1){1'b0}}, irq}, '0);
    tick(1);
    chk("R9 irq_o high one clock later", {{(N-1){1'b0}}, irq}, 1);
    wr(1'b0, '0);
    chk("R9 irq_o still high", {{(N-1){1'b0}}, irq}, 1);
    tick(1);
    chk("R9 irq_o low one clock later", {{(N-1){1'b0}}, irq}, '0);
    rd(1'b1, d);
  endtask

  task automatic t_edge_clear;
    logic [N-1:0] d;
    wr(1'b1, '1);
    rd(1'b1, d); chk("R4 write of ones leaves status", d, 32'h8);
    wr(1'b1, 32'hFFFF_FFF7);
    rd(1'b1, d); chk("R4 write of 0 clears bit 3", d, '0);
  endtask

  task automatic t_set_wins;
    logic [N-1:0] d;
    irq_req[5] = 1'b1; tick(1); irq_req[5] = 1'b0; tick(1);
    irq_req[6] = 1'b1; tick(1); irq_req[6] = 1'b0; tick(1);
    irq_req[5] = 1'b1;
    wr(1'b1, '0);
    irq_req[5] = 1'b0;
    rd(1'b1, d); chk("R5 rise wins over clear on bit 5, bit 6 cleared", d, 32'h20);
    wr(1'b1, '0);
  endtask

  task automatic t_held_high;
    logic [N-1:0] d;
    irq_req[9] = 1'b1;
    tick(1);
    rd(1'b1, d); chk("R2 held line sets bit 9", d, 32'h200);
    wr(1'b1, '0);
    tick(3);
    rd(1'b1, d); chk("R2 held line does not set again", d, '0);
  endtask

  task automatic t_level;
    logic [N-1:0] d;
    level_mode = 1'b1;
    tick(1);
    rd(1'b1, d); chk("R10 first edge still edge mode", d, '0);
    tick(1);
    rd(1'b1, d); chk("R10 level mode follows held bit 9", d, 32'h200);
    wr(1'b1, '0);
    rd(1'b1, d); chk("R7 status write ignored", d, 32'h200);
    irq_req[9] = 1'b0;
    irq_req[11] = 1'b1;
    tick(1);
    rd(1'b1, d); chk("R6 level follows lines", d, 32'h800);
    irq_req[11] = 1'b0;
    wr(1'b1, '1);
    rd(1'b1, d); chk("R6 bit clears when line falls, R7 ones ignored", d, '0);
    level_mode = 1'b0;
    tick(2);
    rd(1'b1, d); chk("R10 back in edge mode, status clear", d, '0);
    irq_req[12] = 1'b1; tick(1); irq_req[12] = 1'b0; tick(2);
    rd(1'b1, d); chk("R3 edge latching restored", d, 32'h1000);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset;
    rst_n = 1'b1;
    tick(2);
    t_reset;
    t_mask_rw;
    t_edge_pulse;
    t_irq_out;
    t_edge_clear;
    t_set_wins;
    t_held_high;
    t_level;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule